// File: doc/BRIEF.md
# Three-Channel Reloading Timer Bank with Free-Running Time Base

This block is a register-mapped timer peripheral. It holds three down-counting channels, two 16 bits wide and one 32 bits wide, plus a 40-bit up-counter that runs freely as a time base. Each channel has a reload register, a live count, a small control byte and a write-only clear location. When a running channel steps past zero it raises its own interrupt line. That line stays high until software writes anything to the channel's clear location.

Two single-cycle clock-enable inputs set the count rates. `tick_slow` is the slow rate and `tick_fast` is the fast rate. Each channel picks one of the two through its control byte. The time base always counts on the fast tick. Software reaches every register over a plain 32-bit bus with an address, a write strobe, write data and combinational read data. To reprogram a channel, software turns it off, writes a new reload value, and then turns it back on.

Top module: `timer_bank`

## Requirements
- R1: After reset, every channel count, reload value and control byte reads 0, all three interrupt lines are low, and both time-base words read 0 with the time base disabled.
- R2: A write to a channel's reload location (offset 0x0 from the channel base; the bases are 0x00, 0x20 and 0x80) sets both the reload value and the live count at once. A load write in the same cycle as a tick leaves the written value. The 16-bit channels keep the low 16 bits. The count reads at offset 0x4 and the reload value at 0x0, both zero-extended to 32 bits.
- R3: While control bit 7 is 1, a channel decrements by one on each cycle of its selected tick. Control bit 3 set to 1 selects `tick_fast` and set to 0 selects `tick_slow`. A tick on the unselected input has no effect.
- R4: With control bit 6 set to 1, a running channel that takes a tick at count 0 reloads from its reload value and raises its interrupt.
- R5: With control bit 6 set to 0, a running channel that takes a tick at count 0 wraps to all ones (0xFFFF or 0xFFFFFFFF) and raises its interrupt.
- R6: A write of any data to a channel's clear location (offset 0xC) drops that channel's interrupt. If an underflow happens in the same cycle, the interrupt stays high.
- R7: Writing 0 to the control location (offset 0x8) stops the channel. Its count then holds through later ticks.
- R8: Writing 1 to bit 8 at 0x64 starts the time base and writing 0 stops it. While it runs it increments once per `tick_fast` cycle. Bits 31:0 read at 0x60. Bits 39:32 read in bits 7:0 at 0x64, and bit 8 there reads back the run state.
- R9: The time base ignores `tick_slow` and never changes any interrupt line.
- R10: The control location reads back only bits 7, 6 and 3 of what was written. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_slow | input | 1 | Slow-rate count enable |
| tick_fast | input | 1 | Fast-rate count enable |
| irq | output | 3 | Interrupt per channel, bit 0 for channel 1 |

## Verification
Within one cycle, a write to a channel's clear location can meet an underflow of that same channel. The rule is that the new underflow wins, so no event is lost. The bench sets this up by holding a running channel at count 0 and then driving the clear write and the selected tick in the same cycle. It expects the interrupt to stay high afterwards, and to drop after a second clear write that comes with no tick. A second collision, a reload write landing on a tick, must leave the written value and not the decremented one.

// File: rtl/tbank_pkg.sv
package tbank_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_CH   = 3;
  localparam int FREE_W   = 40;

  localparam int CTL_EN   = 7;
  localparam int CTL_PER  = 6;
  localparam int CTL_FAST = 3;
  localparam logic [7:0] CTL_MASK = 8'hC8;

  localparam logic [7:0] OFS_LOAD  = 8'h00;
  localparam logic [7:0] OFS_VALUE = 8'h04;
  localparam logic [7:0] OFS_CTL   = 8'h08;
  localparam logic [7:0] OFS_CLR   = 8'h0C;

  localparam logic [7:0] FREE_LO_ADDR = 8'h60;
  localparam logic [7:0] FREE_HI_ADDR = 8'h64;
  localparam int         FREE_RUN_BIT = 8;

  function automatic int ch_width(input int k);
    return (k == 2) ? 32 : 16;
  endfunction

  function automatic logic [7:0] ch_base(input int k);
    case (k)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction
endpackage

// File: rtl/tbank_rst_sync.sv
module tbank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tbank_chan.sv
module tbank_chan
  import tbank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_load,
  input  logic              wr_ctl,
  input  logic              wr_clr,
  input  logic [W-1:0]      wdata,
  input  logic              tick_slow,
  input  logic              tick_fast,
  output logic [DATA_W-1:0] count_out,
  output logic [DATA_W-1:0] reload_out,
  output logic [7:0]        ctl_out,
  output logic              irq
);
  logic [W-1:0] cnt_q, cnt_n;
  logic [W-1:0] rld_q, rld_n;
  logic [7:0]   ctl_q, ctl_n;
  logic         irq_q, irq_n;
  logic         tick_sel, step, at_zero;

  always_comb begin
    tick_sel = ctl_q[CTL_FAST] ? tick_fast : tick_slow;
    step     = ctl_q[CTL_EN] && tick_sel;
    at_zero  = (cnt_q == '0);

    cnt_n = cnt_q;
    rld_n = rld_q;
    ctl_n = ctl_q;
    irq_n = irq_q;

    if (wr_clr) irq_n = 1'b0;

    if (step) begin
      if (at_zero) begin
        cnt_n = ctl_q[CTL_PER] ? rld_q : '1;
        irq_n = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end

    if (wr_ctl) ctl_n = wdata[7:0] & CTL_MASK;

    if (wr_load) begin
      rld_n = wdata;
      cnt_n = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      rld_q <= rld_n;
      ctl_q <= ctl_n;
      irq_q <= irq_n;
    end
  end

  assign count_out  = DATA_W'(cnt_q);
  assign reload_out = DATA_W'(rld_q);
  assign ctl_out    = ctl_q;
  assign irq        = irq_q;
endmodule

// File: rtl/tbank_free.sv
module tbank_free
  import tbank_pkg::*;
#(
  parameter int W = FREE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_run,
  input  logic              run_val,
  input  logic              tick_fast,
  output logic [W-1:0]      count_out,
  output logic              run_out
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         run_q, run_n;

  always_comb begin
    cnt_n = cnt_q;
    run_n = run_q;
    if (run_q && tick_fast) cnt_n = cnt_q + 1'b1;
    if (wr_run) run_n = run_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      run_q <= run_n;
    end
  end

  assign count_out = cnt_q;
  assign run_out   = run_q;
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import tbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  tick_slow,
  input  logic                  tick_fast,
  output logic [NUM_CH-1:0]     irq
);
  localparam int HI_W = FREE_W - DATA_W;

  logic                rst_i_n;
  logic [DATA_W-1:0]   ch_val [NUM_CH];
  logic [DATA_W-1:0]   ch_ld  [NUM_CH];
  logic [7:0]          ch_ctl [NUM_CH];
  logic [FREE_W-1:0]   free_cnt;
  logic                free_run;
  logic                wr_free_hi;

  tbank_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int          CW   = ch_width(k);
    localparam logic [7:0]  BASE = ch_base(k);
    logic wr_load, wr_ctl, wr_clr;

    assign wr_load = bus_we && (bus_addr == ADDR_W'(BASE + OFS_LOAD));
    assign wr_ctl  = bus_we && (bus_addr == ADDR_W'(BASE + OFS_CTL));
    assign wr_clr  = bus_we && (bus_addr == ADDR_W'(BASE + OFS_CLR));

    tbank_chan #(.W(CW)) u_chan (
      .clk        (clk),
      .rst_n      (rst_i_n),
      .wr_load    (wr_load),
      .wr_ctl     (wr_ctl),
      .wr_clr     (wr_clr),
      .wdata      (bus_wdata[CW-1:0]),
      .tick_slow  (tick_slow),
      .tick_fast  (tick_fast),
      .count_out  (ch_val[k]),
      .reload_out (ch_ld[k]),
      .ctl_out    (ch_ctl[k]),
      .irq        (irq[k])
    );
  end

  assign wr_free_hi = bus_we && (bus_addr == ADDR_W'(FREE_HI_ADDR));

  tbank_free #(.W(FREE_W)) u_free (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_run    (wr_free_hi),
    .run_val   (bus_wdata[FREE_RUN_BIT]),
    .tick_fast (tick_fast),
    .count_out (free_cnt),
    .run_out   (free_run)
  );

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (bus_addr == ADDR_W'(ch_base(k) + OFS_LOAD))  bus_rdata = ch_ld[k];
      if (bus_addr == ADDR_W'(ch_base(k) + OFS_VALUE)) bus_rdata = ch_val[k];
      if (bus_addr == ADDR_W'(ch_base(k) + OFS_CTL))   bus_rdata = DATA_W'(ch_ctl[k]);
    end
    if (bus_addr == ADDR_W'(FREE_LO_ADDR)) bus_rdata = free_cnt[DATA_W-1:0];
    if (bus_addr == ADDR_W'(FREE_HI_ADDR))
      bus_rdata = DATA_W'({free_run, free_cnt[FREE_W-1 -: HI_W]});
  end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic        tick_slow,
  input logic        tick_fast,
  input logic        irq3,
  input logic [31:0] cnt3,
  input logic [31:0] ld3,
  input logic        en3,
  input logic        per3,
  input logic        fast3,
  input logic [39:0] free_cnt,
  input logic        free_run
);
  logic tick3, wr3_count, wr3_load, wr3_clr, wr_run, under3;

  assign tick3     = fast3 ? tick_fast : tick_slow;
  assign wr3_load  = bus_we && (bus_addr == 8'h80);
  assign wr3_count = wr3_load || (bus_we && (bus_addr == 8'h88));
  assign wr3_clr   = bus_we && (bus_addr == 8'h8C);
  assign wr_run    = bus_we && (bus_addr == 8'h64);
  assign under3    = en3 && tick3 && (cnt3 == 32'd0);

  assert_load_sets_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr3_load |=> (cnt3 == $past(bus_wdata)));

  assert_reload_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (under3 && per3 && !wr3_count) |=> (cnt3 == $past(ld3)) && irq3);

  assert_wrap_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (under3 && !per3 && !wr3_count) |=> (cnt3 == 32'hFFFF_FFFF) && irq3);

  assert_clear_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr3_clr && !under3) |=> !irq3);

  assert_stopped_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en3 && !wr3_count) |=> $stable(cnt3));

  assert_free_increments_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (free_run && tick_fast && !wr_run) |=> (free_cnt == $past(free_cnt) + 40'd1));
endmodule

bind timer_bank timer_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_i_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .tick_slow (tick_slow),
  .tick_fast (tick_fast),
  .irq3      (irq[2]),
  .cnt3      (ch_val[2]),
  .ld3       (ch_ld[2]),
  .en3       (ch_ctl[2][7]),
  .per3      (ch_ctl[2][6]),
  .fast3     (ch_ctl[2][3]),
  .free_cnt  (free_cnt),
  .free_run  (free_run)
);

// File: tb/timer_bank_test.sv
module timer_bank_test;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tick_slow;
  logic        tick_fast;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;

  timer_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_slow (tick_slow),
    .tick_fast (tick_fast),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick(input bit fast, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
      @(negedge clk);
      tick_fast = 1'b0; tick_slow = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    foreach (d[i]) begin end
    rd(8'h04, d); check("R1", "ch1 count", d, 0);
    rd(8'h24, d); check("R1", "ch2 count", d, 0);
    rd(8'h84, d); check("R1", "ch3 count", d, 0);
    rd(8'h88, d); check("R1", "ch3 control", d, 0);
    rd(8'h60, d); check("R1", "free low", d, 0);
    rd(8'h64, d); check("R1", "free high", d, 0);
    check("R1", "irq", 32'(irq), 0);
  endtask

  task automatic t_load;
    logic [31:0] d;
    wr(8'h00, 32'h0001_2345);
    rd(8'h04, d); check("R2", "ch1 count truncated", d, 32'h2345);
    rd(8'h00, d); check("R2", "ch1 reload truncated", d, 32'h2345);
    wr(8'h80, 32'hDEAD_BEEF);
    rd(8'h84, d); check("R2", "ch3 count", d, 32'hDEAD_BEEF);
    wr(8'h88, 32'h0000_00FF);
    rd(8'h88, d); check("R10", "control readback", d, 32'h0000_00C8);
    wr(8'h88, 32'h0);
    rd(8'h88, d); check("R7", "control zero", d, 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(8'h80, 32'd10);
    wr(8'h88, 32'h0000_00C8);
    tick(1'b1, 3);
    rd(8'h84, d); check("R3", "fast ticks", d, 32'd7);
    tick(1'b0, 2);
    rd(8'h84, d); check("R3", "slow ignored when fast chosen", d, 32'd7);
    wr(8'h88, 32'h0000_00C0);
    tick(1'b0, 2);
    rd(8'h84, d); check("R3", "slow ticks", d, 32'd5);
    tick(1'b1, 2);
    rd(8'h84, d); check("R3", "fast ignored when slow chosen", d, 32'd5);
    // R2: load write landing on a selected tick keeps the written value
    @(negedge clk);
    bus_addr = 8'h80; bus_we = 1'b1; bus_wdata = 32'd40; tick_slow = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_slow = 1'b0;
    rd(8'h84, d); check("R2", "load beats tick", d, 32'd40);
    wr(8'h88, 32'h0);
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    wr(8'h20, 32'd2);
    wr(8'h28, 32'h0000_00C0);
    tick(1'b0, 2);
    rd(8'h24, d); check("R4", "at zero", d, 0);
    check("R4", "irq before underflow", 32'(irq[1]), 0);
    tick(1'b0, 1);
    rd(8'h24, d); check("R4", "reloaded", d, 32'd2);
    check("R4", "irq after underflow", 32'(irq[1]), 1);
    wr(8'h2C, 32'h0);
    check("R6", "clear with zero data", 32'(irq[1]), 0);
    wr(8'h28, 32'h0);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    wr(8'h00, 32'd0);
    wr(8'h08, 32'h0000_0080);
    tick(1'b0, 1);
    rd(8'h04, d); check("R5", "16-bit wrap", d, 32'h0000_FFFF);
    check("R5", "irq on wrap", 32'(irq[0]), 1);
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    check("R6", "clear with ones data", 32'(irq[0]), 0);
    wr(8'h80, 32'd0);
    wr(8'h88, 32'h0000_0088);
    tick(1'b1, 1);
    rd(8'h84, d); check("R5", "32-bit wrap", d, 32'hFFFF_FFFF);
    wr(8'h88, 32'h0);
    wr(8'h8C, 32'h1);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr(8'h80, 32'd0);
    wr(8'h88, 32'h0000_00C8);
    tick(1'b1, 1);
    check("R4", "ch3 irq set", 32'(irq[2]), 1);
    @(negedge clk);
    bus_addr = 8'h8C; bus_we = 1'b1; bus_wdata = 32'h5; tick_fast = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_fast = 1'b0;
    check("R6", "underflow wins over clear", 32'(irq[2]), 1);
    wr(8'h8C, 32'h0);
    check("R6", "plain clear", 32'(irq[2]), 0);
    wr(8'h88, 32'h0);
    rd(8'h84, d); check("R4", "reload of zero", d, 0);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(8'h80, 32'd100);
    wr(8'h88, 32'h0000_00C8);
    tick(1'b1, 1);
    rd(8'h84, d); check("R3", "one step", d, 32'd99);
    wr(8'h88, 32'h0);
    tick(1'b1, 3);
    tick(1'b0, 3);
    rd(8'h84, d); check("R7", "count held", d, 32'd99);
    check("R7", "no irq while stopped", 32'(irq), 0);
  endtask

  task automatic t_free;
    logic [31:0] d;
    tick(1'b1, 2);
    rd(8'h60, d); check("R8", "idle before start", d, 0);
    wr(8'h64, 32'h0000_0100);
    rd(8'h64, d); check("R8", "run bit readback", d, 32'h0000_0100);
    tick(1'b1, 5);
    rd(8'h60, d); check("R8", "low word", d, 32'd5);
    tick(1'b0, 4);
    rd(8'h60, d); check("R9", "slow tick ignored", d, 32'd5);
    check("R9", "no interrupt", 32'(irq), 0);
    wr(8'h64, 32'h0);
    tick(1'b1, 3);
    rd(8'h60, d); check("R8", "stopped holds", d, 32'd5);
    rd(8'h64, d); check("R8", "high word after stop", d, 0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    tick_slow = 1'b0; tick_fast = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load();
    t_count();
    t_periodic();
    t_wrap();
    t_collide();
    t_stop();
    t_free();
    finish_run();
  end
endmodule